// File: doc/BRIEF.md
# Virtually indexed, physically tagged L1 lookup path

This block is the read lookup path of a small direct-mapped level-one data cache. The set index and the byte-within-line offset come only from the low address bits that lie inside a 16 KB page, and those bits are identical in the virtual and the physical address. The tag array and the data array can therefore be read in the same cycle that an 8-entry fully associative translation buffer converts the 18-bit virtual page number into a 14-bit physical page number. One cycle after a request, the stored physical tag of the indexed line is compared with the translated page number. The block then reports a hit together with the selected 32-bit word, a cache miss, or a translation miss.

Two write ports fill the block. The translation refill port loads a virtual-to-physical page pair into the buffer. When the buffer is full, the pair replaces the least recently used entry. The line fill port writes a whole 32-byte line and its physical tag into one set. Page-table walks, memory traffic, coherence and processor stores are handled elsewhere. A translation miss only tells the surrounding logic to run a walk and then refill.

Top module: `vipt_lookup`

## Requirements
- R1: `resp_valid` is high in the cycle directly after a cycle in which `req_valid` was high, and it is low in every other cycle.
- R2: While `resp_valid` is high, exactly one of `resp_hit`, `resp_miss` and `resp_tlb_miss` is high. While `resp_valid` is low, all three are low.
- R3: Reset clears every translation entry and every line valid bit. A lookup after reset reports a translation miss. After a translation refill and before any line fill, a lookup reports a cache miss.
- R4: Request address bits [13:5] select the set, and bits [4:2] select the word. Word k of a line is `fill_data[32k+31:32k]`. Bits [1:0] have no effect on the result.
- R5: A hit requires three things: a translation hit, a valid indexed line, and a stored tag equal to the translated physical page number. If the translation hits and any other condition fails, the result is a cache miss.
- R6: Two virtual pages that translate to the same physical page both hit the same line and return the same data.
- R7: A translation refill for a virtual page that is already present overwrites that entry's physical page number and adds no second entry.
- R8: A refill of a new virtual page uses the lowest-numbered empty entry. When no entry is empty, it replaces the least recently used entry. A refill and a lookup that hits the translation buffer both count as a use.
- R9: A line fill to the set that a lookup reads in the same cycle does not affect that lookup, which returns the old line and tag. In the same way, a refill in the same cycle as a lookup is not visible to that lookup.
- R10: A line fill replaces all 32 bytes and the tag of the set and marks the set valid. Later lookups return the new data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request strobe |
| req_vaddr | input | 32 | Virtual byte address of the lookup |
| resp_valid | output | 1 | Result of the previous cycle's request is present |
| resp_hit | output | 1 | Translation and physical tag both matched |
| resp_miss | output | 1 | Translation matched but the line did not |
| resp_tlb_miss | output | 1 | No translation held for the virtual page |
| resp_data | output | 32 | Selected word of the indexed line |
| xlat_wr_en | input | 1 | Load a translation into the buffer |
| xlat_wr_vpn | input | 18 | Virtual page number to load |
| xlat_wr_ppn | input | 14 | Physical page number to load |
| fill_en | input | 1 | Write one whole line |
| fill_idx | input | 9 | Set that the fill writes |
| fill_ppn | input | 14 | Physical tag stored with the line |
| fill_data | input | 256 | Line contents, word k in bits [32k+31:32k] |

## Verification
The hardest state to reach from the ports is a full translation buffer whose recency order is known, because only then does a refill reveal which entry the replacement logic picks. The stimulus loads the remaining empty entries and then touches seven of the eight pages with lookup hits in a fixed order. It refills a ninth page and checks that the one untouched page now reports a translation miss while the others still hit. A second round repeats this with an order that puts a different page last. Same-cycle collisions are produced by driving a fill or a refill on the same clock edge as a lookup to the same set or page.

// File: rtl/vipt_pkg.sv
package vipt_pkg;
  localparam int VIRT_ADDR_W  = 32;
  localparam int PHYS_ADDR_W  = 28;
  localparam int PAGE_BITS    = 14;
  localparam int LINE_BITS    = 5;
  localparam int DATA_W       = 32;
  localparam int XLAT_ENTRIES = 8;

  typedef enum logic [1:0] {
    RK_IDLE,
    RK_HIT,
    RK_MISS,
    RK_XLAT_MISS
  } res_kind_e;
endpackage

// File: rtl/vipt_xlat_buf.sv
module vipt_xlat_buf #(
  parameter int VPN_W   = 18,
  parameter int PPN_W   = 14,
  parameter int ENTRIES = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               lk_en,
  input  logic [VPN_W-1:0]   lk_vpn,
  output logic               lk_hit,
  output logic [PPN_W-1:0]   lk_ppn,
  output logic [ENTRIES-1:0] lk_match,
  output logic [ENTRIES-1:0] ent_vld,
  input  logic               wr_en,
  input  logic [VPN_W-1:0]   wr_vpn,
  input  logic [PPN_W-1:0]   wr_ppn
);
  localparam int SEL_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [SEL_W-1:0] AGE_MAX = SEL_W'(ENTRIES - 1);

  logic [ENTRIES-1:0] vld_q, vld_d;
  logic [SEL_W-1:0]   age_q [ENTRIES];
  logic [SEL_W-1:0]   age_d [ENTRIES];
  logic [VPN_W-1:0]   vpn_q [ENTRIES];
  logic [PPN_W-1:0]   ppn_q [ENTRIES];

  logic [ENTRIES-1:0] wr_match;
  logic [SEL_W-1:0]   lk_sel, wr_hit_sel, free_sel, old_sel, wr_sel, touch_sel;
  logic               wr_hit, have_free, touch_en;

  // Parallel compare of every entry
  always_comb begin
    lk_match = '0;
    wr_match = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      lk_match[i] = vld_q[i] && (vpn_q[i] == lk_vpn);
      wr_match[i] = vld_q[i] && (vpn_q[i] == wr_vpn);
    end
  end

  always_comb begin
    lk_ppn     = '0;
    lk_sel     = '0;
    wr_hit_sel = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lk_match[i]) begin
        lk_ppn = lk_ppn | ppn_q[i];
        lk_sel = SEL_W'(i);
      end
      if (wr_match[i]) wr_hit_sel = SEL_W'(i);
    end
    lk_hit = |lk_match;
    wr_hit = |wr_match;
  end

  // Victim choice: lowest empty entry, else the oldest one
  always_comb begin
    have_free = 1'b0;
    free_sel  = '0;
    old_sel   = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!vld_q[i]) begin
        have_free = 1'b1;
        free_sel  = SEL_W'(i);
      end
      if (age_q[i] == AGE_MAX) old_sel = SEL_W'(i);
    end
  end

  always_comb begin
    if (wr_hit)         wr_sel = wr_hit_sel;
    else if (have_free) wr_sel = free_sel;
    else                wr_sel = old_sel;
  end

  // A refill takes the recency update over a same-cycle lookup hit
  always_comb begin
    touch_en  = 1'b0;
    touch_sel = '0;
    if (wr_en) begin
      touch_en  = 1'b1;
      touch_sel = wr_sel;
    end else if (lk_en && lk_hit) begin
      touch_en  = 1'b1;
      touch_sel = lk_sel;
    end
  end

  // Next-state for valid bits and ages
  always_comb begin
    vld_d = vld_q;
    for (int i = 0; i < ENTRIES; i++) age_d[i] = age_q[i];
    if (touch_en) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (SEL_W'(i) == touch_sel)          age_d[i] = '0;
        else if (age_q[i] < age_q[touch_sel]) age_d[i] = age_q[i] + 1'b1;
      end
    end
    if (wr_en) vld_d[wr_sel] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      for (int i = 0; i < ENTRIES; i++) age_q[i] <= SEL_W'(i);
    end else begin
      vld_q <= vld_d;
      for (int i = 0; i < ENTRIES; i++) age_q[i] <= age_d[i];
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      vpn_q[wr_sel] <= wr_vpn;
      ppn_q[wr_sel] <= wr_ppn;
    end
  end

  assign ent_vld = vld_q;
endmodule

// File: rtl/vipt_tag_store.sv
module vipt_tag_store #(
  parameter int IDX_W = 9,
  parameter int TAG_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_vld,
  output logic [TAG_W-1:0] rd_tag,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag
);
  localparam int SETS = 1 << IDX_W;

  logic [SETS-1:0]  vld_q, vld_d;
  logic [TAG_W-1:0] tag_mem [SETS];

  always_comb begin
    vld_d = vld_q;
    if (wr_en) vld_d[wr_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= '0;
      rd_vld <= 1'b0;
    end else begin
      vld_q <= vld_d;
      if (rd_en) rd_vld <= vld_q[rd_idx];
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) tag_mem[wr_idx] <= wr_tag;
    if (rd_en) rd_tag <= tag_mem[rd_idx];
  end
endmodule

// File: rtl/vipt_line_store.sv
module vipt_line_store #(
  parameter int IDX_W  = 9,
  parameter int LINE_W = 256
) (
  input  logic              clk,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [LINE_W-1:0] rd_line,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [LINE_W-1:0] wr_line
);
  localparam int SETS = 1 << IDX_W;

  logic [LINE_W-1:0] line_mem [SETS];

  always_ff @(posedge clk) begin
    if (wr_en) line_mem[wr_idx] <= wr_line;
    if (rd_en) rd_line <= line_mem[rd_idx];
  end
endmodule

// File: rtl/vipt_lookup.sv
module vipt_lookup
  import vipt_pkg::*;
#(
  parameter int VA_W      = VIRT_ADDR_W,
  parameter int PA_W      = PHYS_ADDR_W,
  parameter int PG_BITS   = PAGE_BITS,
  parameter int LN_BITS   = LINE_BITS,
  parameter int WORD_W    = DATA_W,
  parameter int XLAT_N    = XLAT_ENTRIES,
  localparam int VPN_W    = VA_W - PG_BITS,
  localparam int PPN_W    = PA_W - PG_BITS,
  localparam int IDX_W    = PG_BITS - LN_BITS,
  localparam int LINE_W   = 8 * (1 << LN_BITS),
  localparam int WORDS    = LINE_W / WORD_W,
  localparam int WSEL_W   = $clog2(WORDS),
  localparam int BYTE_W   = $clog2(WORD_W / 8)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [VA_W-1:0]   req_vaddr,
  output logic              resp_valid,
  output logic              resp_hit,
  output logic              resp_miss,
  output logic              resp_tlb_miss,
  output logic [WORD_W-1:0] resp_data,
  input  logic              xlat_wr_en,
  input  logic [VPN_W-1:0]  xlat_wr_vpn,
  input  logic [PPN_W-1:0]  xlat_wr_ppn,
  input  logic              fill_en,
  input  logic [IDX_W-1:0]  fill_idx,
  input  logic [PPN_W-1:0]  fill_ppn,
  input  logic [LINE_W-1:0] fill_data
);
  logic [VPN_W-1:0]  req_vpn;
  logic [IDX_W-1:0]  req_idx;
  logic [WSEL_W-1:0] req_wsel;
  logic              unused_byte_bits;

  assign req_vpn          = req_vaddr[VA_W-1:PG_BITS];
  assign req_idx          = req_vaddr[PG_BITS-1:LN_BITS];
  assign req_wsel         = req_vaddr[LN_BITS-1:BYTE_W];
  assign unused_byte_bits = ^req_vaddr[BYTE_W-1:0];

  logic              tlb_hit_c;
  logic [PPN_W-1:0]  tlb_ppn_c;
  logic [XLAT_N-1:0] tlb_match;
  logic [XLAT_N-1:0] tlb_vld;

  vipt_xlat_buf #(.VPN_W(VPN_W), .PPN_W(PPN_W), .ENTRIES(XLAT_N)) u_xlat (
    .clk      (clk),
    .rst_n    (rst_n),
    .lk_en    (req_valid),
    .lk_vpn   (req_vpn),
    .lk_hit   (tlb_hit_c),
    .lk_ppn   (tlb_ppn_c),
    .lk_match (tlb_match),
    .ent_vld  (tlb_vld),
    .wr_en    (xlat_wr_en),
    .wr_vpn   (xlat_wr_vpn),
    .wr_ppn   (xlat_wr_ppn)
  );

  logic             line_vld_q;
  logic [PPN_W-1:0] line_tag_q;

  vipt_tag_store #(.IDX_W(IDX_W), .TAG_W(PPN_W)) u_tags (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_en  (req_valid),
    .rd_idx (req_idx),
    .rd_vld (line_vld_q),
    .rd_tag (line_tag_q),
    .wr_en  (fill_en),
    .wr_idx (fill_idx),
    .wr_tag (fill_ppn)
  );

  logic [LINE_W-1:0] line_q;

  vipt_line_store #(.IDX_W(IDX_W), .LINE_W(LINE_W)) u_lines (
    .clk     (clk),
    .rd_en   (req_valid),
    .rd_idx  (req_idx),
    .rd_line (line_q),
    .wr_en   (fill_en),
    .wr_idx  (fill_idx),
    .wr_line (fill_data)
  );

  // Response stage registers, captured alongside the array reads
  logic              rsp_vld_q, rsp_vld_d;
  logic              xl_hit_q, xl_hit_d;
  logic [PPN_W-1:0]  xl_ppn_q;
  logic [WSEL_W-1:0] wsel_q;

  always_comb begin
    rsp_vld_d = req_valid;
    xl_hit_d  = req_valid ? tlb_hit_c : xl_hit_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_vld_q <= 1'b0;
      xl_hit_q  <= 1'b0;
    end else begin
      rsp_vld_q <= rsp_vld_d;
      xl_hit_q  <= xl_hit_d;
    end
  end

  always_ff @(posedge clk) begin
    if (req_valid) begin
      xl_ppn_q <= tlb_ppn_c;
      wsel_q   <= req_wsel;
    end
  end

  // Physical tag compare and result classification
  logic      tag_eq;
  res_kind_e kind;

  always_comb begin
    tag_eq = line_vld_q && (line_tag_q == xl_ppn_q);
    if (!rsp_vld_q)     kind = RK_IDLE;
    else if (!xl_hit_q) kind = RK_XLAT_MISS;
    else if (tag_eq)    kind = RK_HIT;
    else                kind = RK_MISS;
  end

  assign resp_valid    = rsp_vld_q;
  assign resp_hit      = (kind == RK_HIT);
  assign resp_miss     = (kind == RK_MISS);
  assign resp_tlb_miss = (kind == RK_XLAT_MISS);
  assign resp_data     = line_q[wsel_q*WORD_W +: WORD_W];
endmodule

// File: rtl/vipt_lookup_chk.sv
module vipt_lookup_chk #(
  parameter int N = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         req_valid,
  input logic         resp_valid,
  input logic         resp_hit,
  input logic         resp_miss,
  input logic         resp_tlb_miss,
  input logic [N-1:0] tlb_match,
  input logic [N-1:0] tlb_vld
);
  logic armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  // R1: a response follows each request by exactly one cycle
  assert_resp_latency_R1: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    resp_valid == $past(req_valid));

  // R2: one result class per response
  assert_one_result_R2: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> ($countones({resp_hit, resp_miss, resp_tlb_miss}) == 1));

  // R3: nothing is reported right after reset
  assert_quiet_after_reset_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> !resp_valid);

  // R7: no virtual page ever sits in two entries
  assert_unique_vpn_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tlb_match));

  // R8: replacement never drops an entry without loading it
  assert_no_entry_loss_R8: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    $countones(tlb_vld) >= $countones($past(tlb_vld)));
endmodule

bind vipt_lookup vipt_lookup_chk #(.N(XLAT_N)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .resp_valid    (resp_valid),
  .resp_hit      (resp_hit),
  .resp_miss     (resp_miss),
  .resp_tlb_miss (resp_tlb_miss),
  .tlb_match     (tlb_match),
  .tlb_vld       (tlb_vld)
);

// File: tb/tb_vipt_lookup.sv
module tb_vipt_lookup;
  logic         clk;
  logic         rst_n;
  logic         req_valid;
  logic [31:0]  req_vaddr;
  logic         resp_valid, resp_hit, resp_miss, resp_tlb_miss;
  logic [31:0]  resp_data;
  logic         xlat_wr_en;
  logic [17:0]  xlat_wr_vpn;
  logic [13:0]  xlat_wr_ppn;
  logic         fill_en;
  logic [8:0]   fill_idx;
  logic [13:0]  fill_ppn;
  logic [255:0] fill_data;

  vipt_lookup dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_miss(resp_miss),
    .resp_tlb_miss(resp_tlb_miss), .resp_data(resp_data),
    .xlat_wr_en(xlat_wr_en), .xlat_wr_vpn(xlat_wr_vpn), .xlat_wr_ppn(xlat_wr_ppn),
    .fill_en(fill_en), .fill_idx(fill_idx), .fill_ppn(fill_ppn), .fill_data(fill_data)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int  n_tests = 0;
  int  n_fail  = 0;
  bit  done    = 1'b0;

  localparam logic [1:0] OP_LK   = 2'd0;
  localparam logic [1:0] OP_XLAT = 2'd1;
  localparam logic [1:0] OP_FILL = 2'd2;
  localparam logic [2:0] E_HIT   = 3'b100;
  localparam logic [2:0] E_MISS  = 3'b010;
  localparam logic [2:0] E_XMISS = 3'b001;

  typedef struct packed {
    logic [1:0]  op;
    logic [17:0] vpn;
    logic [8:0]  idx;
    logic [2:0]  w;
    logic [1:0]  b;
    logic [13:0] ppn;
    logic [15:0] seed;
    logic [2:0]  exp;
    logic [31:0] edata;
  } vec_t;

  localparam vec_t VECS [0:15] = '{
    {OP_LK,   18'h5, 9'd3, 3'd0, 2'd0, 14'h000, 16'h0000, E_XMISS, 32'h0},
    {OP_XLAT, 18'h5, 9'd0, 3'd0, 2'd0, 14'h100, 16'h0000, E_HIT,   32'h0},
    {OP_LK,   18'h5, 9'd3, 3'd0, 2'd0, 14'h000, 16'h0000, E_MISS,  32'h0},
    {OP_FILL, 18'h0, 9'd3, 3'd0, 2'd0, 14'h100, 16'h1111, E_HIT,   32'h0},
    {OP_LK,   18'h5, 9'd3, 3'd2, 2'd0, 14'h000, 16'h0000, E_HIT,   32'h1111_0002},
    {OP_LK,   18'h5, 9'd3, 3'd7, 2'd3, 14'h000, 16'h0000, E_HIT,   32'h1111_0007},
    {OP_XLAT, 18'h9, 9'd0, 3'd0, 2'd0, 14'h100, 16'h0000, E_HIT,   32'h0},
    {OP_LK,   18'h9, 9'd3, 3'd5, 2'd1, 14'h000, 16'h0000, E_HIT,   32'h1111_0005},
    {OP_XLAT, 18'hA, 9'd0, 3'd0, 2'd0, 14'h200, 16'h0000, E_HIT,   32'h0},
    {OP_LK,   18'hA, 9'd3, 3'd0, 2'd0, 14'h000, 16'h0000, E_MISS,  32'h0},
    {OP_LK,   18'h5, 9'd4, 3'd0, 2'd0, 14'h000, 16'h0000, E_MISS,  32'h0},
    {OP_FILL, 18'h0, 9'd3, 3'd0, 2'd0, 14'h200, 16'h2222, E_HIT,   32'h0},
    {OP_LK,   18'hA, 9'd3, 3'd1, 2'd0, 14'h000, 16'h0000, E_HIT,   32'h2222_0001},
    {OP_LK,   18'h5, 9'd3, 3'd0, 2'd0, 14'h000, 16'h0000, E_MISS,  32'h0},
    {OP_XLAT, 18'h5, 9'd0, 3'd0, 2'd0, 14'h200, 16'h0000, E_HIT,   32'h0},
    {OP_LK,   18'h5, 9'd3, 3'd6, 2'd0, 14'h000, 16'h0000, E_HIT,   32'h2222_0006}
  };

  string vec_req [0:15] = '{"R3", "R3", "R3", "R10", "R4", "R4", "R6", "R6",
                            "R5", "R5", "R4", "R10", "R10", "R5", "R7", "R7"};

  function automatic logic [255:0] mkline(input logic [15:0] seed);
    logic [255:0] l;
    for (int k = 0; k < 8; k++) l[32*k +: 32] = {seed, 16'(k)};
    return l;
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    req_valid  = 1'b0; req_vaddr   = '0;
    xlat_wr_en = 1'b0; xlat_wr_vpn = '0; xlat_wr_ppn = '0;
    fill_en    = 1'b0; fill_idx    = '0; fill_ppn    = '0; fill_data = '0;
  endtask

  task automatic check_result(input string req, input logic [2:0] exp, input logic [31:0] edata);
    check(req, "result", {28'd0, resp_valid, resp_hit, resp_miss, resp_tlb_miss}, {28'd0, 1'b1, exp});
    if (exp == E_HIT) check(req, "data", resp_data, edata);
  endtask

  task automatic lookup(input logic [17:0] vpn, input logic [8:0] idx, input logic [2:0] w,
                        input logic [1:0] b, input logic [2:0] exp, input logic [31:0] edata,
                        input string req);
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = {vpn, idx, w, b};
    @(negedge clk);
    req_valid = 1'b0;
    check_result(req, exp, edata);
  endtask

  task automatic refill(input logic [17:0] vpn, input logic [13:0] ppn);
    @(negedge clk);
    xlat_wr_en = 1'b1; xlat_wr_vpn = vpn; xlat_wr_ppn = ppn;
    @(negedge clk);
    xlat_wr_en = 1'b0;
  endtask

  task automatic fill(input logic [8:0] idx, input logic [13:0] ppn, input logic [15:0] seed);
    @(negedge clk);
    fill_en = 1'b1; fill_idx = idx; fill_ppn = ppn; fill_data = mkline(seed);
    @(negedge clk);
    fill_en = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    idle_inputs();
    repeat (3) @(negedge clk);
    // R3: nothing reported while reset is held
    check("R3", "resp_valid in reset", {31'd0, resp_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "resp_valid idle", {31'd0, resp_valid}, 32'd0);

    for (int i = 0; i < 16; i++) begin
      case (VECS[i].op)
        OP_LK:   lookup(VECS[i].vpn, VECS[i].idx, VECS[i].w, VECS[i].b,
                        VECS[i].exp, VECS[i].edata, vec_req[i]);
        OP_XLAT: refill(VECS[i].vpn, VECS[i].ppn);
        default: fill(VECS[i].idx, VECS[i].ppn, VECS[i].seed);
      endcase
    end

    // R1: no response in the cycle after a response without a new request
    @(negedge clk);
    check("R1", "resp_valid after gap", {31'd0, resp_valid}, 32'd0);

    // R9: fill to the set being read on the same edge returns the old line
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = {18'hA, 9'd3, 3'd4, 2'd0};
    fill_en = 1'b1; fill_idx = 9'd3; fill_ppn = 14'h200; fill_data = mkline(16'h3333);
    @(negedge clk);
    req_valid = 1'b0; fill_en = 1'b0;
    check_result("R9", E_HIT, 32'h2222_0004);
    lookup(18'hA, 9'd3, 3'd4, 2'd0, E_HIT, 32'h3333_0004, "R10");

    // R9: refill on the same edge as the lookup is not seen by it
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = {18'h30, 9'd3, 3'd0, 2'd0};
    xlat_wr_en = 1'b1; xlat_wr_vpn = 18'h30; xlat_wr_ppn = 14'h200;
    @(negedge clk);
    req_valid = 1'b0; xlat_wr_en = 1'b0;
    check_result("R9", E_XMISS, 32'h0);
    lookup(18'h30, 9'd3, 3'd0, 2'd0, E_HIT, 32'h3333_0000, "R9");

    // R8: fill the buffer, touch all but page 9, then overflow
    for (int v = 'h31; v <= 'h34; v++) refill(18'(v), 14'h200);
    lookup(18'h5, 9'd3, 3'd1, 2'd0, E_HIT, 32'h3333_0001, "R8");
    lookup(18'hA, 9'd3, 3'd1, 2'd0, E_HIT, 32'h3333_0001, "R8");
    lookup(18'h30, 9'd3, 3'd1, 2'd0, E_HIT, 32'h3333_0001, "R8");
    for (int v = 'h31; v <= 'h34; v++)
      lookup(18'(v), 9'd3, 3'd2, 2'd0, E_HIT, 32'h3333_0002, "R8");
    refill(18'h40, 14'h200);
    lookup(18'h9, 9'd3, 3'd0, 2'd0, E_XMISS, 32'h0, "R8");
    lookup(18'h40, 9'd3, 3'd3, 2'd0, E_HIT, 32'h3333_0003, "R8");
    lookup(18'h5, 9'd3, 3'd3, 2'd0, E_HIT, 32'h3333_0003, "R8");
    // R8: page A is now the oldest
    refill(18'h41, 14'h200);
    lookup(18'hA, 9'd3, 3'd0, 2'd0, E_XMISS, 32'h0, "R8");
    lookup(18'h30, 9'd3, 3'd5, 2'd0, E_HIT, 32'h3333_0005, "R8");
    lookup(18'h41, 9'd3, 3'd6, 2'd0, E_HIT, 32'h3333_0006, "R8");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule